// File: doc/BRIEF.md
# SDRAM Single-Burst Access Controller with Byte-Lane Masking

This block runs one complete access on a 16-bit, two-bank SDR SDRAM for a single user port. A request carries the direction, bank, row, column, an auto-precharge choice and, for writes, four data beats. The controller opens the row, waits the row-to-column delay, and issues the column command. It then moves four beats in a fixed burst, with CAS latency 2 on reads. Each beat has its own two-bit lane mask, which drives the byte mask pins. Bit 0 of a beat's mask covers the low byte and bit 1 covers the high byte.

The mask pins serve both directions, but data follows them differently. On a write, the mask is presented in the same cycle as the beat it suppresses. On a read, the mask is presented two cycles before the beat, and the device then leaves that lane undriven. The controller lines up both cases from one beat counter. It captures read data CAS-latency cycles after each beat slot and reports only beats that are not fully masked. It signals completion and then, after an optional precharge wait, becomes ready again.

Top module: `sdram_burst_ctrl`

## Requirements
- R1: With ready_o high, a request pulse makes the controller issue ACTIVE in the next cycle. ACTIVE carries the row on the address bus and the bank on the bank output. The command pins {cs_n,ras_n,cas_n,we_n} are encoded NOP=0111, ACTIVE=0011, READ=0101 and WRITE=0100, and the clock enable stays high.
- R2: The column command is issued exactly TRCD cycles after ACTIVE (default 2), with NOP in every cycle between them.
- R3: The column command carries the column on address bits 7:0, zero on bits 9:8, the auto-precharge choice on bit 10 and the request's bank. During ACTIVE, bit 10 carries row data.
- R4: A write drives beat k (bits 16k+15:16k of the write data) on the data bus in cycle C+k, where C is the column command cycle, for k = 0..3. The output enable is high only in those four cycles.
- R5: In cycle C+k the mask pins carry bits 2k+1:2k of the request mask (bit 0 is the low byte), for reads and writes alike. Outside those cycles the mask pins are 00.
- R6: On a read, beat k is sampled from the data bus in cycle C+2+k and shown on rd_data_o with rd_valid_o in cycle C+3+k. A lane whose mask bit is set reads as zero.
- R7: A read beat whose two mask bits are both set produces no rd_valid_o pulse. rd_valid_o never rises during a write.
- R8: done_o pulses for exactly one cycle: in cycle C+4 for a write and C+6 for a read, which is the same cycle as the last read beat.
- R9: ready_o is low from acceptance until the cycle after done_o. When auto-precharge was chosen, it stays low for TRP further cycles (default 2). Requests presented while ready_o is low are ignored.
- R10: During reset and right after it, the command is NOP, ready_o is high, and the output enable, rd_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when ready_o is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_ap_i | input | 1 | Auto-precharge after the burst |
| req_bank_i | input | 1 | Bank select |
| req_row_i | input | 12 | Row address |
| req_col_i | input | 8 | Column address |
| req_wdata_i | input | 64 | Four write beats, beat 0 in the low bits |
| req_mask_i | input | 8 | Two mask bits per beat, beat 0 in the low bits |
| ready_o | output | 1 | Controller idle and accepting |
| done_o | output | 1 | Access finished pulse |
| rd_data_o | output | 16 | Captured read beat |
| rd_valid_o | output | 1 | rd_data_o holds a beat |
| sd_cke_o | output | 1 | Clock enable |
| sd_cs_n_o | output | 1 | Chip select |
| sd_ras_n_o | output | 1 | Row strobe |
| sd_cas_n_o | output | 1 | Column strobe |
| sd_we_n_o | output | 1 | Write enable |
| sd_ba_o | output | 1 | Bank address |
| sd_addr_o | output | 12 | Address bus |
| sd_dqm_o | output | 2 | Byte masks, bit 0 low byte |
| sd_dq_o | output | 16 | Data bus out |
| sd_dq_oe_o | output | 1 | Data bus drive enable |
| sd_dq_i | input | 16 | Data bus in |

## Verification
On a read, the cycle that delivers the final beat on rd_valid_o is also the cycle in which done_o pulses. Read requests of all mask kinds provoke this coincidence: unmasked, partially masked and with the last beat fully masked. In the last case done_o must appear with no valid pulse. A second meeting point is the release of ready_o at the same clock edge where a held request is taken. The bench keeps req_i high through busy periods, so a new ACTIVE must follow the first ready cycle, and no earlier one. The behavioural model predicts every port in every cycle and compares them.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_RCD,
    ST_BURST,
    ST_DRAIN,
    ST_DONE,
    ST_PRECH
  } seq_state_e;

endpackage

// File: rtl/sbc_req_hold.sv
module sbc_req_hold #(
  parameter int BANK_W = 1,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 16,
  parameter int LANES  = 2,
  parameter int BL     = 4,
  parameter int BEAT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  we_i,
  input  logic                  ap_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [BL*DQ_W-1:0]    wdata_i,
  input  logic [BL*LANES-1:0]   mask_i,
  input  logic [BEAT_W-1:0]     beat_i,
  output logic                  we_o,
  output logic                  ap_o,
  output logic [BANK_W-1:0]     bank_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [COL_W-1:0]      col_o,
  output logic [DQ_W-1:0]       beat_data_o,
  output logic [LANES-1:0]      beat_mask_o
);

  logic [BL*DQ_W-1:0]  wdata_q;
  logic [BL*LANES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      ap_o    <= 1'b0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (load_i) begin
      we_o    <= we_i;
      ap_o    <= ap_i;
      bank_o  <= bank_i;
      row_o   <= row_i;
      col_o   <= col_i;
      wdata_q <= wdata_i;
      mask_q  <= mask_i;
    end
  end

  assign beat_data_o = wdata_q[beat_i*DQ_W +: DQ_W];
  assign beat_mask_o = mask_q[beat_i*LANES +: LANES];

endmodule

// File: rtl/sbc_sequencer.sv
module sbc_sequencer
  import sdram_burst_pkg::*;
#(
  parameter int TRCD   = 2,
  parameter int TRP    = 2,
  parameter int CL     = 2,
  parameter int BL     = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ap_i,
  output sd_cmd_e           cmd_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              burst_o,
  output logic              load_o,
  output logic              ready_o,
  output logic              done_o
);

  localparam int CNT_MAX = (TRCD > TRP) ? ((TRCD > CL) ? TRCD : CL)
                                        : ((TRP > CL) ? TRP : CL);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_OPEN;
      ST_OPEN: begin
        beat_d = '0;
        if (TRCD > 1) begin
          state_d = ST_RCD;
          cnt_d   = CNT_W'(TRCD - 1);
        end else begin
          state_d = ST_BURST;
        end
      end
      ST_RCD: begin
        if (cnt_q == CNT_W'(1)) state_d = ST_BURST;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      ST_BURST: begin
        if (beat_q == BEAT_W'(BL - 1)) begin
          if (we_i) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_DRAIN;
            cnt_d   = CNT_W'(CL);
          end
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (cnt_q == CNT_W'(1)) state_d = ST_DONE;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      ST_DONE: begin
        if (ap_i && (TRP > 0)) begin
          state_d = ST_PRECH;
          cnt_d   = CNT_W'(TRP);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PRECH: begin
        if (cnt_q == CNT_W'(1)) state_d = ST_IDLE;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (state_q == ST_OPEN) cmd_o = CMD_ACT;
    else if (state_q == ST_BURST && beat_q == '0) cmd_o = we_i ? CMD_WRITE : CMD_READ;
  end

  assign beat_o  = beat_q;
  assign burst_o = (state_q == ST_BURST);
  assign ready_o = (state_q == ST_IDLE);
  assign load_o  = ready_o && req_i;
  assign done_o  = (state_q == ST_DONE);

  p_accept_opens_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ready_o) |=> (cmd_o == CMD_ACT));

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> !ready_o);

  if (TRCD > 1) begin : g_rcd_chk
    p_nop_before_column_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_READ || cmd_o == CMD_WRITE) |-> ($past(cmd_o) == CMD_NOP));
  end

endmodule

// File: rtl/sbc_rd_capture.sv
module sbc_rd_capture #(
  parameter int DQ_W  = 16,
  parameter int LANES = 2,
  parameter int CL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DQ_W-1:0]  dq_i,
  output logic [DQ_W-1:0]  rd_data_o,
  output logic             rd_valid_o
);

  localparam int LANE_W = DQ_W / LANES;

  logic [CL-1:0]    slot_v_q;
  logic [LANES-1:0] slot_m_q [CL];
  logic [DQ_W-1:0]  cap_d;
  logic             tail_v;
  logic [LANES-1:0] tail_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q    <= '0;
      slot_m_q[0] <= '0;
    end else begin
      slot_v_q[0] <= issue_i;
      slot_m_q[0] <= mask_i;
    end
  end

  for (genvar s = 1; s < CL; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v_q[s] <= 1'b0;
        slot_m_q[s] <= '0;
      end else begin
        slot_v_q[s] <= slot_v_q[s-1];
        slot_m_q[s] <= slot_m_q[s-1];
      end
    end
  end

  assign tail_v = slot_v_q[CL-1];
  assign tail_m = slot_m_q[CL-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cap_d[l*LANE_W +: LANE_W] = tail_m[l] ? '0 : dq_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= tail_v && !(&tail_m);
      if (tail_v) rd_data_o <= cap_d;
    end
  end

  p_valid_after_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(issue_i, CL + 1));

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 16,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int TRCD   = 2,
  parameter int TRP    = 2,
  parameter int AP_BIT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic                       req_we_i,
  input  logic                       req_ap_i,
  input  logic [BANK_W-1:0]          req_bank_i,
  input  logic [ROW_W-1:0]           req_row_i,
  input  logic [COL_W-1:0]           req_col_i,
  input  logic [BL*DQ_W-1:0]         req_wdata_i,
  input  logic [BL*(DQ_W/8)-1:0]     req_mask_i,
  output logic                       ready_o,
  output logic                       done_o,
  output logic [DQ_W-1:0]            rd_data_o,
  output logic                       rd_valid_o,
  output logic                       sd_cke_o,
  output logic                       sd_cs_n_o,
  output logic                       sd_ras_n_o,
  output logic                       sd_cas_n_o,
  output logic                       sd_we_n_o,
  output logic [BANK_W-1:0]          sd_ba_o,
  output logic [ROW_W-1:0]           sd_addr_o,
  output logic [DQ_W/8-1:0]          sd_dqm_o,
  output logic [DQ_W-1:0]            sd_dq_o,
  output logic                       sd_dq_oe_o,
  input  logic [DQ_W-1:0]            sd_dq_i
);

  localparam int LANES  = DQ_W / 8;
  localparam int BEAT_W = (BL > 1) ? $clog2(BL) : 1;

  sd_cmd_e           cmd;
  logic [BEAT_W-1:0] beat;
  logic              in_burst, load;
  logic              we_q, ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   beat_data;
  logic [LANES-1:0]  beat_mask;

  sbc_req_hold #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .LANES(LANES), .BL(BL), .BEAT_W(BEAT_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .we_i(req_we_i), .ap_i(req_ap_i), .bank_i(req_bank_i),
    .row_i(req_row_i), .col_i(req_col_i), .wdata_i(req_wdata_i),
    .mask_i(req_mask_i), .beat_i(beat),
    .we_o(we_q), .ap_o(ap_q), .bank_o(bank_q), .row_o(row_q), .col_o(col_q),
    .beat_data_o(beat_data), .beat_mask_o(beat_mask)
  );

  sbc_sequencer #(
    .TRCD(TRCD), .TRP(TRP), .CL(CL), .BL(BL), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_q), .ap_i(ap_q),
    .cmd_o(cmd), .beat_o(beat), .burst_o(in_burst), .load_o(load),
    .ready_o(ready_o), .done_o(done_o)
  );

  sbc_rd_capture #(
    .DQ_W(DQ_W), .LANES(LANES), .CL(CL)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .issue_i(in_burst && !we_q),
    .mask_i(beat_mask), .dq_i(sd_dq_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  assign sd_cke_o = 1'b1;
  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

  always_comb begin
    sd_addr_o = '0;
    sd_ba_o   = '0;
    unique case (cmd)
      CMD_ACT: begin
        sd_addr_o = row_q;
        sd_ba_o   = bank_q;
      end
      CMD_READ, CMD_WRITE: begin
        sd_addr_o[COL_W-1:0] = col_q;
        sd_addr_o[AP_BIT]    = ap_q;
        sd_ba_o              = bank_q;
      end
      default: ;
    endcase
  end

  assign sd_dqm_o   = in_burst ? beat_mask : '0;
  assign sd_dq_oe_o = in_burst && we_q;
  assign sd_dq_o    = sd_dq_oe_o ? beat_data : '0;

  p_drive_starts_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_dq_oe_o) |-> (cmd == CMD_WRITE));

  p_no_read_beat_while_driving_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe_o |-> !rd_valid_o);

endmodule

// File: tb/sdram_burst_ctrl_tb.sv
module sdram_burst_ctrl_tb;

  localparam int TRCD = 2;
  localparam int TRP  = 2;
  localparam int CL   = 2;
  localparam int BL   = 4;
  localparam int NTX  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, req_we_i, req_ap_i;
  logic [0:0]  req_bank_i;
  logic [11:0] req_row_i;
  logic [7:0]  req_col_i;
  logic [63:0] req_wdata_i;
  logic [7:0]  req_mask_i;
  logic        ready_o, done_o, rd_valid_o;
  logic [15:0] rd_data_o;
  logic        sd_cke_o, sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic [0:0]  sd_ba_o;
  logic [11:0] sd_addr_o;
  logic [1:0]  sd_dqm_o;
  logic [15:0] sd_dq_o, sd_dq_i;
  logic        sd_dq_oe_o;

  always #5 clk = ~clk;

  sdram_burst_ctrl #(.TRCD(TRCD), .TRP(TRP), .CL(CL), .BL(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
    .req_ap_i(req_ap_i), .req_bank_i(req_bank_i), .req_row_i(req_row_i),
    .req_col_i(req_col_i), .req_wdata_i(req_wdata_i), .req_mask_i(req_mask_i),
    .ready_o(ready_o), .done_o(done_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .sd_cke_o(sd_cke_o), .sd_cs_n_o(sd_cs_n_o),
    .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o), .sd_we_n_o(sd_we_n_o),
    .sd_ba_o(sd_ba_o), .sd_addr_o(sd_addr_o), .sd_dqm_o(sd_dqm_o),
    .sd_dq_o(sd_dq_o), .sd_dq_oe_o(sd_dq_oe_o), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic        t_we [NTX];
  logic        t_ap [NTX];
  logic        t_bank [NTX];
  logic [11:0] t_row [NTX];
  logic [7:0]  t_col [NTX];
  logic [63:0] t_dat [NTX];
  logic [7:0]  t_msk [NTX];
  int          t_gap [NTX];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive_req(input int i);
    req_i       = 1'b1;
    req_we_i    = t_we[i];
    req_ap_i    = t_ap[i];
    req_bank_i  = t_bank[i];
    req_row_i   = t_row[i];
    req_col_i   = t_col[i];
    req_wdata_i = t_dat[i];
    req_mask_i  = t_msk[i];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    int unsigned lf;
    int  ti, phase, cc, dd, endp, k, gap;
    bit  active, pend, ready_now;
    bit  cw, ca;
    logic        cb;
    logic [11:0] crow;
    logic [7:0]  ccol, cmsk;
    logic [63:0] cdat;
    logic [3:0]  ecmd, acmd;
    logic [15:0] ed;
    logic [1:0]  em;
    bit          ev;

    lf = 32'h1ACE_B00C;
    for (int i = 0; i < NTX; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      t_dat[i] = {lf, lf ^ 32'h5A5A_C3C3};
      t_row[i] = lf[27:16];
      t_col[i] = lf[7:0];
      t_bank[i] = lf[9];
      t_we[i] = lf[3];
      t_ap[i] = lf[12];
      t_msk[i] = lf[23:16];
      t_gap[i] = (i % 3 == 1) ? 3 : 0;
    end
    // directed corner cases
    t_we[0] = 1; t_ap[0] = 0; t_msk[0] = 8'h00; t_row[0] = 12'hFFF;
    t_we[1] = 0; t_ap[1] = 0; t_msk[1] = 8'h00;
    t_we[2] = 1; t_ap[2] = 1; t_msk[2] = 8'h0C;  // beat 1 fully masked
    t_we[3] = 0; t_ap[3] = 1; t_msk[3] = 8'h0C;
    t_we[4] = 0; t_ap[4] = 0; t_msk[4] = 8'hFF;  // every read beat masked
    t_we[5] = 1; t_ap[5] = 1; t_msk[5] = 8'hFF;
    t_we[6] = 0; t_ap[6] = 1; t_msk[6] = 8'h66;  // single lanes masked
    t_we[7] = 1; t_ap[7] = 0; t_msk[7] = 8'h99;
    t_we[8] = 0; t_ap[8] = 0; t_msk[8] = 8'hC0;  // last read beat fully masked

    rst_n = 1'b0; req_i = 1'b0; req_we_i = 0; req_ap_i = 0; req_bank_i = 0;
    req_row_i = 0; req_col_i = 0; req_wdata_i = 0; req_mask_i = 0; sd_dq_i = 0;

    repeat (3) begin
      @(negedge clk);
      acmd = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
      chk(acmd == 4'b0111, "R10", "reset cmd", 64'(acmd), 64'h7);
      chk(ready_o && !done_o && !rd_valid_o && !sd_dq_oe_o, "R10", "reset flags",
          64'({ready_o, done_o, rd_valid_o, sd_dq_oe_o}), 64'h8);
    end
    rst_n = 1'b1;

    ti = 0; active = 0; pend = 0; phase = 0; gap = t_gap[0];
    cw = 0; ca = 0; cb = 0; crow = 0; ccol = 0; cmsk = 0; cdat = 0;
    cc = TRCD; dd = 0; endp = 0;

    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      if (pend) begin
        active = 1; phase = 0; pend = 0;
        cw = t_we[ti-1]; ca = t_ap[ti-1]; cb = t_bank[ti-1]; crow = t_row[ti-1];
        ccol = t_col[ti-1]; cmsk = t_msk[ti-1]; cdat = t_dat[ti-1];
        dd = cw ? cc + BL : cc + BL + CL;
        endp = dd + (ca ? TRP : 0);
      end else if (active) begin
        phase++;
      end

      // device side: drive read beats, garbage on masked lanes
      sd_dq_i = 16'h0;
      if (active && !cw && phase >= cc + CL && phase < cc + CL + BL) begin
        k = phase - cc - CL;
        sd_dq_i = cdat[k*16 +: 16];
        if (cmsk[2*k])   sd_dq_i[7:0]  = 8'hA5;
        if (cmsk[2*k+1]) sd_dq_i[15:8] = 8'h3C;
      end

      // expected values from the requirements
      ecmd = 4'b0111; em = 2'b00; ev = 0; ed = 16'h0;
      if (active) begin
        if (phase == 0) ecmd = 4'b0011;
        else if (phase == cc) ecmd = cw ? 4'b0100 : 4'b0101;
        if (phase >= cc && phase < cc + BL) em = cmsk[2*(phase-cc) +: 2];
        if (!cw && phase >= cc + CL + 1 && phase < cc + CL + 1 + BL) begin
          k = phase - cc - CL - 1;
          ev = (cmsk[2*k +: 2] != 2'b11);
          ed = cdat[k*16 +: 16];
          if (cmsk[2*k])   ed[7:0]  = 8'h00;
          if (cmsk[2*k+1]) ed[15:8] = 8'h00;
        end
      end

      acmd = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
      chk(acmd == ecmd && sd_cke_o, "R1/R2", "command", 64'({sd_cke_o, acmd}), 64'({1'b1, ecmd}));
      if (active && phase == 0) begin
        chk(sd_addr_o == crow && sd_ba_o == cb, "R1", "row/bank",
            64'({sd_ba_o, sd_addr_o}), 64'({cb, crow}));
      end
      if (active && phase == cc) begin
        chk(sd_addr_o == {1'b0, ca, 2'b00, ccol} && sd_ba_o == cb, "R3", "column/bank",
            64'({sd_ba_o, sd_addr_o}), 64'({cb, 1'b0, ca, 2'b00, ccol}));
      end
      if (active && cw && phase >= cc && phase < cc + BL) begin
        chk(sd_dq_oe_o && sd_dq_o == cdat[(phase-cc)*16 +: 16], "R4", "write beat",
            64'({sd_dq_oe_o, sd_dq_o}), 64'({1'b1, cdat[(phase-cc)*16 +: 16]}));
      end else begin
        chk(!sd_dq_oe_o, "R4", "drive enable", 64'(sd_dq_oe_o), 64'h0);
      end
      chk(sd_dqm_o == em, "R5", "byte mask", 64'(sd_dqm_o), 64'(em));
      chk(rd_valid_o == ev, "R7", "read valid", 64'(rd_valid_o), 64'(ev));
      if (ev) chk(rd_data_o == ed, "R6", "read data", 64'(rd_data_o), 64'(ed));
      chk(done_o == (active && phase == dd), "R8", "done", 64'(done_o),
          64'(active && phase == dd));
      ready_now = !active;
      chk(ready_o == ready_now, "R9", "ready", 64'(ready_o), 64'(ready_now));

      if (active && phase == endp) active = 0;

      // stimulus for the coming edge; held requests while busy must be ignored
      if (ti < NTX) begin
        if (ready_now && gap > 0) begin
          req_i = 1'b0;
          gap--;
        end else begin
          drive_req(ti);
          if (ready_now) begin
            pend = 1;
            ti++;
            gap = (ti < NTX) ? t_gap[ti] : 0;
          end
        end
      end else begin
        req_i = 1'b0;
        if (!active && !pend) break;
      end
    end

    chk(ti == NTX && !active, "R9", "all requests taken", 64'(ti), 64'(NTX));
    finished = 1;
    summary();
  end

endmodule